// File: doc/BRIEF.md
# Prioritised Pending Interrupt Selector

This block keeps one pending bit for each of twelve asynchronous interrupt sources of a processor core. Sources raise their bit with a one-cycle set strobe and software lowers it with a clear strobe. When the entry sequencer pulses the evaluation request, the block picks the single highest-priority source that the machine state allows. It reports that source as a one-cycle valid pulse carrying a 4-bit exception code. It also drops the pending bit of the chosen source when that source is of the consumed kind.

Some sources are consumed on delivery. Others, the external and critical external inputs, behave like levels and stay pending until software clears them. The decrementer follows a configuration input. A hard-interrupt request line tells the core that something may be pending. The line goes low only after an evaluation that leaves nothing pending.

Top module: `irq_pending_selector`

## Requirements
- R1: Code 0 (system reset, set bit 0) outranks everything, and code 1 (machine check, bit 1) outranks all remaining sources. Neither needs any enable bit, and each pending bit is cleared when its source is delivered.
- R2: Code 2 (critical external, bit 2) is delivered only while `crit_en_i` is 1, and its pending bit is kept after delivery.
- R3: Codes 3 to 11 need `ext_en_i` = 1, and with it they rank in this order, highest first: 3 watchdog, 4 critical doorbell, 5 fixed-interval timer, 6 programmable timer, 7 decrementer, 8 external, 9 doorbell, 10 performance monitor, 11 thermal. With `ext_en_i` = 0 none of them is delivered.
- R4: Delivery of codes 3, 4, 5, 6, 9, 10 or 11 clears that source's pending bit.
- R5: Delivery of code 8 (external) leaves its pending bit set.
- R6: Delivery of code 7 (decrementer) clears its pending bit only when `dec_take_clr_i` is 1.
- R7: An evaluation requested in one cycle gives `take_valid_o` = 1 for exactly the next cycle, with the code of the one chosen source. When no source is deliverable, `take_valid_o` stays 0. `take_code_o` is 0 whenever `take_valid_o` is 0.
- R8: `irq_req_o` goes high in the cycle after any set strobe. After an evaluation it equals whether any bit is still pending. Otherwise it holds its value.
- R9: When a set strobe meets a clear strobe or a delivery clear on the same bit in the same cycle, the bit ends up set.
- R10: A clear strobe on bit i removes source i from pending, so it is not delivered afterwards unless set again.
- R11: After reset nothing is pending, and `take_valid_o`, `take_code_o` and `irq_req_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_i | input | 12 | Per-source set strobes, bit i = code i |
| clr_i | input | 12 | Per-source clear strobes, bit i = code i |
| eval_i | input | 1 | Evaluation request from the entry sequencer |
| ext_en_i | input | 1 | External-enable bit of the machine state |
| crit_en_i | input | 1 | Critical-enable bit of the machine state |
| dec_take_clr_i | input | 1 | Decrementer is cleared when delivered |
| take_valid_o | output | 1 | One-cycle pulse: a source was chosen |
| take_code_o | output | 4 | Exception code of the chosen source |
| irq_req_o | output | 1 | Hard-interrupt request line |

## Verification
The bench targets the level-like sources. A design that consumed the external or critical bit would deliver them once instead of on every evaluation. The decrementer is run under both settings of its configuration bit, because a wrong consumption rule shows up as a missing or extra repeat delivery. Set-versus-clear collisions on the chosen bit are forced; a design that let the clear win would lose a fresh interrupt. The request line is watched across evaluations that do and do not empty the register, since a line that tracks pending directly would drop on a software clear before any evaluation.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  localparam int NUM_SRC = 12;
  localparam int CODE_W  = $clog2(NUM_SRC);

  localparam int SRC_RST   = 0;
  localparam int SRC_MCK   = 1;
  localparam int SRC_CRIT  = 2;
  localparam int SRC_WDOG  = 3;
  localparam int SRC_CDB   = 4;
  localparam int SRC_FIT   = 5;
  localparam int SRC_PIT   = 6;
  localparam int SRC_DEC   = 7;
  localparam int SRC_EXT   = 8;
  localparam int SRC_DB    = 9;
  localparam int SRC_PERF  = 10;
  localparam int SRC_THERM = 11;

  typedef logic [NUM_SRC-1:0] src_vec_t;
  typedef logic [CODE_W-1:0]  code_t;

  // Sources whose pending bit is dropped on delivery (decrementer by config)
  function automatic src_vec_t consume_mask(input logic dec_clr);
    src_vec_t m;
    m = '1;
    m[SRC_CRIT] = 1'b0;
    m[SRC_EXT]  = 1'b0;
    m[SRC_DEC]  = dec_clr;
    return m;
  endfunction
endpackage

// File: rtl/irq_enable_gate.sv
module irq_enable_gate
  import irq_sel_pkg::*;
(
  input  src_vec_t pend_i,
  input  logic     ext_en_i,
  input  logic     crit_en_i,
  output src_vec_t elig_o
);
  src_vec_t allow;

  always_comb begin
    allow = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (i == SRC_RST || i == SRC_MCK) allow[i] = 1'b1;
      else if (i == SRC_CRIT)           allow[i] = crit_en_i;
      else                              allow[i] = ext_en_i;
    end
    elig_o = pend_i & allow;
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_sel_pkg::*;
(
  input  src_vec_t elig_i,
  output logic     found_o,
  output code_t    idx_o
);
  // Lowest index wins: scan from the top so lower indices overwrite
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (elig_i[i]) begin
        found_o = 1'b1;
        idx_o   = code_t'(i);
      end
    end
  end
endmodule

// File: rtl/irq_pending_selector.sv
module irq_pending_selector
  import irq_sel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [11:0]       set_i,
  input  logic [11:0]       clr_i,
  input  logic              eval_i,
  input  logic              ext_en_i,
  input  logic              crit_en_i,
  input  logic              dec_take_clr_i,
  output logic              take_valid_o,
  output logic [3:0]        take_code_o,
  output logic              irq_req_o
);
  src_vec_t pend_q, pend_d, elig, take_clr;
  logic     found;
  code_t    pick_idx;
  logic     valid_q, valid_d, irq_q, irq_d;
  code_t    code_q, code_d;

  irq_enable_gate u_gate (
    .pend_i    (pend_q),
    .ext_en_i  (ext_en_i),
    .crit_en_i (crit_en_i),
    .elig_o    (elig)
  );

  irq_prio_pick u_pick (
    .elig_i  (elig),
    .found_o (found),
    .idx_o   (pick_idx)
  );

  // Next state
  always_comb begin
    take_clr = '0;
    if (eval_i && found)
      take_clr[pick_idx] = consume_mask(dec_take_clr_i)[pick_idx];
    pend_d  = (pend_q & ~clr_i & ~take_clr) | set_i;
    valid_d = eval_i && found;
    code_d  = valid_d ? pick_idx : '0;
    if (eval_i)      irq_d = |pend_d;
    else if (|set_i) irq_d = 1'b1;
    else             irq_d = irq_q;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      valid_q <= 1'b0;
      code_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      valid_q <= valid_d;
      code_q  <= code_d;
      irq_q   <= irq_d;
    end
  end

  assign take_valid_o = valid_q;
  assign take_code_o  = code_q;
  assign irq_req_o    = irq_q;

  // R7
  valid_after_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid_o |-> $past(eval_i));

  // R2
  crit_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid_o && take_code_o == 4'(SRC_CRIT)) |-> $past(crit_en_i));

  // R5
  ext_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q[SRC_EXT] && !clr_i[SRC_EXT]) |=> pend_q[SRC_EXT]);

  // R8
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_req_o) |-> (pend_q == '0));

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((pend_q & $past(set_i)) == $past(set_i)));

  // R1
  reset_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && pend_q[SRC_RST]) |=> (take_valid_o && take_code_o == 4'(SRC_RST)));
endmodule

// File: tb/irq_pending_selector_tb.sv
module irq_pending_selector_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] set_i = '0, clr_i = '0;
  logic        eval_i = 1'b0, ext_en_i = 1'b0, crit_en_i = 1'b0, dec_take_clr_i = 1'b0;
  logic        take_valid_o, irq_req_o;
  logic [3:0]  take_code_o;

  int errors = 0, checks = 0;
  logic [11:0] m_pend = '0;
  logic        m_irq = 1'b0, m_valid = 1'b0;
  logic [3:0]  m_code = '0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  irq_pending_selector u_dut (
    .clk(clk), .rst_n(rst_n), .set_i(set_i), .clr_i(clr_i), .eval_i(eval_i),
    .ext_en_i(ext_en_i), .crit_en_i(crit_en_i), .dec_take_clr_i(dec_take_clr_i),
    .take_valid_o(take_valid_o), .take_code_o(take_code_o), .irq_req_o(irq_req_o)
  );

  // Priority choice from the requirements: returns 12 when nothing is deliverable
  function automatic int choose(logic [11:0] p, logic ee, logic ce);
    for (int i = 0; i < 12; i++) begin
      if (p[i]) begin
        if (i < 2) return i;
        if (i == 2 && ce) return i;
        if (i > 2 && ee) return i;
      end
    end
    return 12;
  endfunction

  function automatic logic consumed(int c, logic dcfg);
    if (c == 2 || c == 8) return 1'b0;
    if (c == 7) return dcfg;
    return 1'b1;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Apply inputs for one cycle, update model, compare just after the edge
  task automatic step(logic [11:0] s, logic [11:0] c, logic ev, string req);
    logic [11:0] tclr;
    int pick;
    @(negedge clk);
    set_i = s; clr_i = c; eval_i = ev;
    @(posedge clk);
    pick = choose(m_pend, ext_en_i, crit_en_i);
    tclr = '0;
    m_valid = ev && pick < 12;
    m_code  = m_valid ? 4'(pick) : 4'd0;
    if (m_valid && consumed(pick, dec_take_clr_i)) tclr[pick] = 1'b1;
    m_pend = (m_pend & ~c & ~tclr) | s;
    if (ev) m_irq = |m_pend;
    else if (|s) m_irq = 1'b1;
    #1;
    check(req, 16'(take_valid_o), 16'(m_valid), "valid");
    check(req, 16'(take_code_o), 16'(m_code), "code");
    check(req, 16'(irq_req_o), 16'(m_irq), "irq_req");
  endtask

  task automatic expect_take(string req, logic v, int code);
    check(req, 16'(take_valid_o), 16'(v), "directed valid");
    if (v) check(req, 16'(take_code_o), 16'(code), "directed code");
  endtask

  task automatic drain();
    step('0, '1, 1'b1, "R10");
    step('0, '0, 1'b0, "R10");
  endtask

  initial begin
    #20000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    check("R11", 16'(take_valid_o), 16'd0, "reset valid");
    check("R11", 16'(take_code_o), 16'd0, "reset code");
    check("R11", 16'(irq_req_o), 16'd0, "reset irq");
    @(negedge clk); rst_n = 1'b1;

    // R1: reset and machine check over everything, no enables needed
    ext_en_i = 0; crit_en_i = 0;
    step(12'hFFF, '0, 1'b0, "R8");
    step('0, '0, 1'b1, "R1"); expect_take("R1", 1, 0);
    step('0, '0, 1'b1, "R1"); expect_take("R1", 1, 1);
    // R3: with ext disabled, nothing further; R2 crit disabled
    step('0, '0, 1'b1, "R3"); expect_take("R3", 0, 0);
    crit_en_i = 1;
    step('0, '0, 1'b1, "R2"); expect_take("R2", 1, 2);
    step('0, '0, 1'b1, "R2"); expect_take("R2", 1, 2);
    // R3 ordering with ext enabled, critical off
    crit_en_i = 0; ext_en_i = 1; dec_take_clr_i = 1;
    for (int k = 3; k <= 7; k++) begin
      step('0, '0, 1'b1, "R3"); expect_take("R3", 1, k);
    end
    // R5: external repeats until cleared
    step('0, '0, 1'b1, "R5"); expect_take("R5", 1, 8);
    step('0, '0, 1'b1, "R5"); expect_take("R5", 1, 8);
    step('0, 12'h100, 1'b0, "R10");
    // R8: irq holds after software clear without evaluation
    check("R8", 16'(irq_req_o), 16'd1, "held");
    for (int k = 9; k <= 11; k++) begin
      step('0, '0, 1'b1, "R4"); expect_take("R4", 1, k);
    end
    // remaining: crit pending (level) -> clear it and drop irq
    step('0, 12'h004, 1'b0, "R10");
    step('0, '0, 1'b1, "R8"); expect_take("R8", 0, 0);
    check("R8", 16'(irq_req_o), 16'd0, "dropped");

    // R6: decrementer kept when config is 0
    dec_take_clr_i = 0;
    step(12'h080, '0, 1'b0, "R6");
    step('0, '0, 1'b1, "R6"); expect_take("R6", 1, 7);
    step('0, '0, 1'b1, "R6"); expect_take("R6", 1, 7);
    dec_take_clr_i = 1;
    step('0, '0, 1'b1, "R6"); expect_take("R6", 1, 7);
    step('0, '0, 1'b1, "R6"); expect_take("R6", 0, 0);

    // R9: set collides with delivery clear and with clear strobe
    step(12'h008, '0, 1'b0, "R9");
    step(12'h008, 12'h008, 1'b1, "R9"); expect_take("R9", 1, 3);
    step('0, '0, 1'b1, "R9"); expect_take("R9", 1, 3);
    drain();

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      logic [11:0] s, c;
      s = ($urandom_range(0, 3) == 0) ? 12'(1 << $urandom_range(0, 11)) : '0;
      if ($urandom_range(0, 7) == 0) s |= 12'($urandom);
      c = ($urandom_range(0, 5) == 0) ? 12'(1 << $urandom_range(0, 11)) : '0;
      if ($urandom_range(0, 15) == 0) begin
        ext_en_i = 1'($urandom); crit_en_i = 1'($urandom);
        dec_take_clr_i = 1'($urandom);
      end
      step(s & ~12'h003 | (($urandom_range(0, 40) == 0) ? s : '0), c,
           1'($urandom_range(0, 2) == 0), "R7");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule